// File: doc/BRIEF.md
# SECDED Codec for a 64-bit Word with Stuck-Word Detection

This block protects a 64-bit data word with 8 check bits, for a 72-bit stored word. It has two halves. A combinational encoder turns 64 data bits into the 8 check bits that are stored beside them. A registered decoder takes a 72-bit word read back from storage and returns three things:

- the data, with any single-bit error corrected;
- a flag that a single bit was corrected;
- a flag for an error that cannot be corrected.

The decoder also raises its own flag when the word read back is all zeros or all ones. That is the usual sign of a dead or unpowered array, and the block reports it as an uncorrectable condition.

The code has odd-weight columns, so every single-bit error gives a syndrome of odd weight. Every double-bit error gives a nonzero syndrome of even weight. Two check bits are stored inverted. Because of this, neither the all-zero word nor the all-one word is a legal codeword, and both give an even-weight syndrome that is never mistaken for a correctable error. Errors of three or more bits are not guaranteed to be caught. Storage, bus protocol, error logging and address capture all sit outside the block.

Top module: `secded_codec`

## Requirements
- R1: For data bit k, the column is the k-th value in a list of 8-bit values. The list holds every weight-3 value in ascending numeric order, then weight-5 values in ascending numeric order until there are 64 entries. Check bit i equals the XOR of the data bits whose column has bit i set, XORed with bit i of the inversion constant 8'h81. The encoder output is combinational.
- R2: A read presented with `rd_valid_i` high appears on the outputs at the next rising clock edge, with `rd_valid_o` high for that one cycle. While `rd_valid_i` is low, `rd_valid_o` goes low and the data and flag outputs hold their previous values, whatever `rd_word_i` carries.
- R3: The stored word layout is data in bits [63:0] and check bits in bits [71:64]. A word whose check field equals the encoding of its data field returns that data with all three flags low.
- R4: A word with exactly one flipped data bit returns the original data, with `rd_corr_o` high and the other two flags low.
- R5: A word with exactly one flipped check bit returns the data field unchanged, with `rd_corr_o` high and the other two flags low.
- R6: A word with exactly two flipped bits, in any positions, raises `rd_uncorr_o` with `rd_corr_o` low. The data output is then the raw data field.
- R7: A word read back as 72 zeros or 72 ones raises `rd_stuck_o`, with the other two flags low and the raw data field on `rd_data_o`.
- R8: The encoding of all-zero data and the encoding of all-one data are both stored words that are neither all zeros nor all ones.
- R9: While `rst_ni` is low, `rd_valid_o`, `rd_data_o` and all flags are zero.
- R10: At most one of `rd_corr_o`, `rd_uncorr_o` and `rd_stuck_o` is high in any cycle. When the stuck condition applies, its flag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 64 | Data to encode |
| enc_chk_o | output | 8 | Check bits for `enc_data_i` |
| rd_valid_i | input | 1 | A stored word is presented for decoding |
| rd_word_i | input | 72 | Stored word: check bits [71:64], data [63:0] |
| rd_valid_o | output | 1 | Decoded result is valid this cycle |
| rd_data_o | output | 64 | Corrected (or raw) data |
| rd_corr_o | output | 1 | A single-bit error was corrected |
| rd_uncorr_o | output | 1 | Error that cannot be corrected |
| rd_stuck_o | output | 1 | Word read back as all zeros or all ones |

## Verification
The decoder holds only one register stage, so a wrong syndrome, a wrong column table or a wrong class decision shows on the data and flags exactly one clock after the read is presented. A column table that is skewed between the encoder and the error locator breaks clean round-trips at once. It also shows when a single-bit flip is corrected at the wrong position, or when the wrong flag comes up. A wrong hold or valid register shows on the first idle cycle after a read, because the outputs must stay put while a different word sits on the input.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned CHK_W  = 8;
    localparam int unsigned WORD_W = DATA_W + CHK_W;
    localparam int unsigned SYN_VALS = 1 << CHK_W;

    // check bits stored inverted so that stuck words are never legal
    localparam logic [CHK_W-1:0] CHK_INV = 8'h81;

    typedef logic [DATA_W-1:0][CHK_W-1:0] col_tbl_t;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_CORR   = 2'd1,
        CLS_UNCORR = 2'd2,
        CLS_STUCK  = 2'd3
    } cls_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              uncorr;
        logic              stuck;
    } rd_res_t;

    function automatic int unsigned weight_of(logic [CHK_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int unsigned b = 0; b < CHK_W; b++) begin
            n += {31'd0, v[b]};
        end
        return n;
    endfunction

    // weight-3 columns first, then weight-5, each ascending
    function automatic col_tbl_t build_cols();
        col_tbl_t    t;
        int unsigned n;
        int unsigned w;
        t = '0;
        n = 0;
        for (int unsigned pass = 0; pass < 2; pass++) begin
            w = (pass == 0) ? 3 : 5;
            for (int unsigned v = 1; v < SYN_VALS; v++) begin
                if (weight_of(CHK_W'(v)) == w && n < DATA_W) begin
                    t[n] = CHK_W'(v);
                    n++;
                end
            end
        end
        return t;
    endfunction

    localparam col_tbl_t H_COLS = build_cols();

    function automatic logic [DATA_W-1:0] row_mask(int unsigned row);
        logic [DATA_W-1:0] m;
        for (int unsigned k = 0; k < DATA_W; k++) begin
            m[k] = H_COLS[k][row];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar i = 0; i < CHK_W; i++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(i);
        assign chk_o[i] = (^(data_i & MASK)) ^ CHK_INV[i];
    end

endmodule

// File: rtl/secded_locate.sv
`timescale 1ns/1ps
module secded_locate
    import secded_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] flip_o,
    output logic              hit_o
);

    logic [CHK_W-1:0] chk_hit;

    for (genvar k = 0; k < DATA_W; k++) begin : g_data
        assign flip_o[k] = (syn_i == H_COLS[k]);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [CHK_W-1:0] UNIT = CHK_W'(1) << j;
        assign chk_hit[j] = (syn_i == UNIT);
    end

    assign hit_o = (|flip_o) | (|chk_hit);

endmodule

// File: rtl/secded_dec_core.sv
`timescale 1ns/1ps
module secded_dec_core
    import secded_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output cls_e              cls_o
);

    logic [DATA_W-1:0] raw_data;
    logic [CHK_W-1:0]  raw_chk;
    logic [CHK_W-1:0]  calc_chk;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic              hit;
    logic              all_zero;
    logic              all_one;

    assign raw_data = word_i[DATA_W-1:0];
    assign raw_chk  = word_i[WORD_W-1:DATA_W];

    secded_enc u_recalc (
        .data_i (raw_data),
        .chk_o  (calc_chk)
    );

    assign syn = calc_chk ^ raw_chk;

    secded_locate u_locate (
        .syn_i  (syn),
        .flip_o (flip),
        .hit_o  (hit)
    );

    assign all_zero = (word_i == '0);
    assign all_one  = (&word_i);

    always_comb begin
        data_o = raw_data;
        if (all_zero || all_one) begin
            cls_o = CLS_STUCK;
        end else if (syn == '0) begin
            cls_o = CLS_CLEAN;
        end else if (hit) begin
            cls_o  = CLS_CORR;
            data_o = raw_data ^ flip;
        end else begin
            cls_o = CLS_UNCORR;
        end
    end

endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_chk_o,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_corr_o,
    output logic              rd_uncorr_o,
    output logic              rd_stuck_o
);

    logic [DATA_W-1:0] core_data;
    cls_e              core_cls;
    rd_res_t           res_d;
    rd_res_t           res_q;

    secded_enc u_enc (
        .data_i (enc_data_i),
        .chk_o  (enc_chk_o)
    );

    secded_dec_core u_core (
        .word_i (rd_word_i),
        .data_o (core_data),
        .cls_o  (core_cls)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (rd_valid_i) begin
            res_d.valid  = 1'b1;
            res_d.data   = core_data;
            res_d.corr   = (core_cls == CLS_CORR);
            res_d.uncorr = (core_cls == CLS_UNCORR);
            res_d.stuck  = (core_cls == CLS_STUCK);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_valid_o  = res_q.valid;
    assign rd_data_o   = res_q.data;
    assign rd_corr_o   = res_q.corr;
    assign rd_uncorr_o = res_q.uncorr;
    assign rd_stuck_o  = res_q.stuck;

endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
module secded_codec_chk
    import secded_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CHK_W-1:0]  enc_chk_o,
    input logic              rd_valid_i,
    input logic [WORD_W-1:0] rd_word_i,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_corr_o,
    input logic              rd_uncorr_o,
    input logic              rd_stuck_o
);

    assert_flags_onehot0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rd_corr_o, rd_uncorr_o, rd_stuck_o}));

    assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_i |=> rd_valid_o);

    assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_i |=> !rd_valid_o);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_i |=> ($stable(rd_data_o) && $stable(rd_corr_o)
                         && $stable(rd_uncorr_o) && $stable(rd_stuck_o)));

    assert_stuck_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_i && ((rd_word_i == '0) || (&rd_word_i))) |=> (rd_stuck_o && !rd_uncorr_o));

    assert_round_trip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_i && (rd_word_i[DATA_W-1:0] == enc_data_i)
         && (rd_word_i[WORD_W-1:DATA_W] == enc_chk_o))
        |=> (!rd_corr_o && !rd_uncorr_o && !rd_stuck_o
             && (rd_data_o == $past(enc_data_i))));

    assert_zero_enc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enc_data_i == '0) |-> (enc_chk_o != '0));

    assert_ones_enc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&enc_data_i) |-> (enc_chk_o != '1));

endmodule

bind secded_codec secded_codec_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enc_data_i  (enc_data_i),
    .enc_chk_o   (enc_chk_o),
    .rd_valid_i  (rd_valid_i),
    .rd_word_i   (rd_word_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rd_corr_o   (rd_corr_o),
    .rd_uncorr_o (rd_uncorr_o),
    .rd_stuck_o  (rd_stuck_o)
);

// File: tb/secded_codec_bench.sv
`timescale 1ns/1ps
module secded_codec_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] enc_data_i = '0;
    logic [7:0]  enc_chk_o;
    logic        rd_valid_i = 1'b0;
    logic [71:0] rd_word_i = '0;
    logic        rd_valid_o;
    logic [63:0] rd_data_o;
    logic        rd_corr_o;
    logic        rd_uncorr_o;
    logic        rd_stuck_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i;

    secded_codec u_secded_codec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enc_data_i  (enc_data_i),
        .enc_chk_o   (enc_chk_o),
        .rd_valid_i  (rd_valid_i),
        .rd_word_i   (rd_word_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .rd_corr_o   (rd_corr_o),
        .rd_uncorr_o (rd_uncorr_o),
        .rd_stuck_o  (rd_stuck_o)
    );

    // reference: columns listed by weight (3 then 5), ascending value
    function automatic logic [7:0] ref_col(int k);
        int idx = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < 256; v++) begin
                if ($countones(v[7:0]) == w) begin
                    if (idx == k) return v[7:0];
                    idx++;
                end
            end
        end
        return 8'h00;
    endfunction

    logic [7:0] ref_tbl [64];

    function automatic logic [7:0] ref_chk(logic [63:0] d);
        logic [7:0] c = 8'h81;
        for (int k = 0; k < 64; k++) begin
            if (d[k]) c ^= ref_tbl[k];
        end
        return c;
    endfunction

    function automatic logic [71:0] ref_word(logic [63:0] d);
        return {ref_chk(d), d};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [71:0] act,
                         input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present one word, sample the registered result one edge later
    task automatic read_word(input logic [71:0] w);
        @(negedge clk_i);
        rd_valid_i = 1'b1;
        rd_word_i  = w;
        @(negedge clk_i);
        rd_valid_i = 1'b0;
    endtask

    task automatic expect_result(input string tag, input logic [63:0] d,
                                 input logic [2:0] flags);
        logic [2:0] got;
        got = {rd_corr_o, rd_uncorr_o, rd_stuck_o};
        check(rd_valid_o && rd_data_o == d && got == flags, tag,
              {rd_valid_o, 4'h0, got, rd_data_o}, {1'b1, 4'h0, flags, d});
        check($countones(got) <= 1, "R10 flags exclusive", {69'd0, got}, 72'd0);
    endtask

    task automatic t_reset();
        check(!rd_valid_o && rd_data_o == '0 && !rd_corr_o && !rd_uncorr_o && !rd_stuck_o,
              "R9 reset state", {rd_valid_o, rd_corr_o, rd_uncorr_o, rd_stuck_o, 4'h0, rd_data_o},
              72'd0);
    endtask

    task automatic t_encode();
        logic [63:0] pats [4] = '{64'h0123_4567_89ab_cdef, 64'h8000_0000_0000_0001,
                                  64'hdead_beef_f00d_cafe, 64'h5555_aaaa_3333_cccc};
        foreach (pats[i]) begin
            @(negedge clk_i);
            enc_data_i = pats[i];
            #1;
            check(enc_chk_o == ref_chk(pats[i]), "R1 encoder check bits",
                  {64'd0, enc_chk_o}, {64'd0, ref_chk(pats[i])});
        end
    endtask

    task automatic t_enc_nonstuck();
        logic [71:0] w;
        enc_data_i = '0;
        #1;
        w = {enc_chk_o, 64'd0};
        check(w != '0 && w != '1, "R8 zero data encodes to non-stuck word", w, 72'd0);
        enc_data_i = '1;
        #1;
        w = {enc_chk_o, 64'hffff_ffff_ffff_ffff};
        check(w != '0 && w != '1, "R8 ones data encodes to non-stuck word", w, '1);
    endtask

    task automatic t_clean();
        logic [63:0] d;
        for (int i = 0; i < 6; i++) begin
            d = {$urandom, $urandom};
            read_word(ref_word(d));
            expect_result("R3 clean word", d, 3'b000);
        end
    endtask

    task automatic t_single_data();
        logic [63:0] d;
        int p;
        for (int i = 0; i < 40; i++) begin
            d = {$urandom, $urandom};
            p = (i < 2) ? i * 63 : int'($urandom_range(63, 0));
            read_word(ref_word(d) ^ (72'd1 << p));
            expect_result("R4 single data flip corrected", d, 3'b100);
        end
    endtask

    task automatic t_single_chk();
        logic [63:0] d;
        for (int j = 0; j < 8; j++) begin
            d = {$urandom, $urandom};
            read_word(ref_word(d) ^ (72'd1 << (64 + j)));
            expect_result("R5 single check flip", d, 3'b100);
        end
    endtask

    task automatic t_double();
        logic [63:0] d;
        logic [71:0] w;
        int a;
        int b;
        for (int i = 0; i < 40; i++) begin
            d = {$urandom, $urandom};
            a = int'($urandom_range(71, 0));
            b = (a + 1 + int'($urandom_range(70, 0))) % 72;
            w = ref_word(d) ^ (72'd1 << a) ^ (72'd1 << b);
            if (w != '0 && w != '1) begin
                read_word(w);
                expect_result("R6 double flip uncorrectable", w[63:0], 3'b010);
            end
        end
    endtask

    task automatic t_stuck();
        read_word('0);
        expect_result("R7 all-zero word", 64'd0, 3'b001);
        read_word('1);
        expect_result("R7 all-one word", 64'hffff_ffff_ffff_ffff, 3'b001);
    endtask

    task automatic t_hold();
        logic [63:0] d;
        d = 64'h0f0f_1234_5678_9abc;
        read_word(ref_word(d) ^ 72'd4);
        expect_result("R2 one-cycle result", d, 3'b100);
        rd_word_i = '0;
        @(negedge clk_i);
        check(!rd_valid_o && rd_data_o == d && rd_corr_o && !rd_stuck_o,
              "R2 idle holds outputs", {rd_valid_o, 7'd0, rd_data_o}, {1'b0, 7'd0, d});
    endtask

    initial begin
        for (int k = 0; k < 64; k++) ref_tbl[k] = ref_col(k);
        void'($urandom(7));
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_encode();
        t_enc_nonstuck();
        t_clean();
        t_single_data();
        t_single_chk();
        t_double();
        t_stuck();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule